// File: doc/BRIEF.md
# Multiprocessor Address-Filtering Receive Gate

This block sits between the receive shift register of a serial port and its receive buffer. Each time a character finishes, it decides whether the character goes into the buffer. On a multi-drop line, one controller addresses several listeners. A listener with its filtering mode on takes only address characters. It drops data characters silently, so software is never told they arrived. After software has compared the address and found a match, it turns the mode off. From then on every character passes, until software turns the mode back on.

The marker that tells an address character from a data character comes from one of two places, depending on the character size. For nine-bit characters it is the top data bit. For five- to eight-bit characters it is the first stop bit. A marker of one means address and zero means data. Accepted characters go out with their unused upper bits cleared and with the marker, so that software can read the ninth bit back. The error flags that come with a character are forwarded only when that character is accepted.

Top module: `mpf_rx_gate`

## Requirements
- R1: When `size_sel` is 4, 5, 6 or 7 (nine-bit characters), the frame-type bit is `chr_data[8]`, and `acc_addr` reports it on every accepted character.
- R2: When `size_sel` is 0, 1, 2 or 3 (characters of 5, 6, 7 or 8 bits), the frame-type bit is `stop1_bit`, and `acc_addr` reports it on every accepted character.
- R3: While `mode_on` is 1, a completed character whose frame-type bit is 0 (data) leaves `acc_stb` at 0.
- R4: While `mode_on` is 1, a completed character whose frame-type bit is 1 (address) raises `acc_stb` in the same cycle as `chr_done`.
- R5: While `mode_on` is 0, every completed character raises `acc_stb` in the same cycle as `chr_done`, whatever its frame-type bit.
- R6: `mode_on` is 0 after reset. A `mode_set` pulse makes it 1 from the next clock edge. A `mode_clr` pulse alone makes it 0 from the next clock edge. When both pulse in the same cycle, the set wins.
- R7: The accept decision uses the value that `mode_on` has when `chr_done` arrives. A mode write in that same cycle affects only later characters.
- R8: On `acc_data`, the data bits at and above the configured character size (5, 6, 7, 8 or 9 bits) are 0, and the bits below it equal `chr_data`.
- R9: `acc_fe` and `acc_pe` follow `fe_in` and `pe_in` only while `acc_stb` is 1. Otherwise both are 0, including for a discarded data character.
- R10: `acc_stb` is 0 in every cycle in which `chr_done` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chr_done | input | 1 | One-cycle strobe: a character has been fully shifted in |
| chr_data | input | 9 | Completed character, LSB first bit received |
| stop1_bit | input | 1 | Value sampled for the first stop bit |
| size_sel | input | 3 | Character size: 0..3 give 5..8 bits, 4..7 give 9 bits |
| fe_in | input | 1 | Frame error of the completed character |
| pe_in | input | 1 | Parity error of the completed character |
| mode_set | input | 1 | Software pulse that turns filtering on |
| mode_clr | input | 1 | Software pulse that turns filtering off |
| acc_stb | output | 1 | Character accepted into the receive buffer |
| acc_data | output | 9 | Accepted character with unused bits cleared |
| acc_addr | output | 1 | Frame-type bit of the accepted character |
| acc_fe | output | 1 | Frame error, qualified by acceptance |
| acc_pe | output | 1 | Parity error, qualified by acceptance |
| mode_on | output | 1 | Current filtering mode |

## Verification
The accept strobe, the data, the frame-type flag and the error flags are combinational from the inputs and the mode register, so they are due in the same cycle as `chr_done`. The bench drives each character on a falling edge and samples these outputs a short delay later, before the next rising edge. A mode write becomes visible one rising edge later. The bench therefore checks `mode_on` in the half-cycle after that edge. In the cycle where the write and a character coincide, it checks the accept decision before that edge.

// File: rtl/mpf_pkg.sv
package mpf_pkg;
  parameter int unsigned MPF_MIN_BITS  = 5;
  parameter int unsigned MPF_MAX_BITS  = 9;
  parameter int unsigned MPF_WIDE_CODE = 4;

  // Number of data bits for a size code: codes below the wide threshold
  // count up from the minimum, codes at or above it select the maximum.
  function automatic int unsigned char_bits(input int unsigned code);
    if (code >= MPF_WIDE_CODE) return MPF_MAX_BITS;
    return MPF_MIN_BITS + code;
  endfunction
endpackage

// File: rtl/mpf_mode_reg.sv
module mpf_mode_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic mode_q
);
  logic mode_en;
  logic mode_d;

  always_comb begin
    mode_en = set_i | clr_i;
    mode_d  = set_i;          // set has priority over clear
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mode_q <= 1'b0;
    else if (mode_en) mode_q <= mode_d;
  end

  assert_set_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> mode_q);
  assert_clr_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> !mode_q);
  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_i && !clr_i) |=> $stable(mode_q));
endmodule

// File: rtl/mpf_frame_decode.sv
module mpf_frame_decode #(
  parameter int unsigned DATA_W = 9,
  parameter int unsigned SZ_W   = 3
) (
  input  logic [DATA_W-1:0] raw_i,
  input  logic              stop1_i,
  input  logic [SZ_W-1:0]   size_i,
  output logic [DATA_W-1:0] masked_o,
  output logic              ftype_o
);
  localparam int unsigned MSB  = DATA_W - 1;
  localparam int unsigned CNTW = $clog2(DATA_W + 1);

  logic              wide;
  logic [CNTW-1:0]   nbits;
  logic [DATA_W-1:0] keep;

  always_comb begin
    wide  = (size_i >= SZ_W'(mpf_pkg::MPF_WIDE_CODE));
    nbits = CNTW'(mpf_pkg::char_bits(int'(size_i)));
  end

  for (genvar i = 0; i < DATA_W; i++) begin : g_keep
    assign keep[i] = (nbits > CNTW'(i));
  end

  always_comb begin
    masked_o = raw_i & keep;
    ftype_o  = wide ? raw_i[MSB] : stop1_i;
  end

  always_comb begin
    assert_mask_top_R8: assert (wide || !masked_o[MSB]);
  end
endmodule

// File: rtl/mpf_accept_gate.sv
module mpf_accept_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic done_i,
  input  logic ftype_i,
  input  logic mode_i,
  input  logic fe_i,
  input  logic pe_i,
  output logic acc_o,
  output logic fe_o,
  output logic pe_o
);
  logic pass;

  always_comb begin
    pass  = ~mode_i | ftype_i;
    acc_o = done_i & pass;
    fe_o  = acc_o & fe_i;
    pe_o  = acc_o & pe_i;
  end

  assert_drop_data_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i && !ftype_i) |-> !acc_o);
  assert_take_addr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i && ftype_i && done_i) |-> acc_o);
  assert_open_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_i && done_i) |-> acc_o);
  assert_err_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_o |-> (!fe_o && !pe_o));
  assert_no_spurious_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !done_i |-> !acc_o);
endmodule

// File: rtl/mpf_rx_gate.sv
module mpf_rx_gate #(
  parameter int unsigned DATA_W = 9,
  parameter int unsigned SZ_W   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chr_done,
  input  logic [DATA_W-1:0] chr_data,
  input  logic              stop1_bit,
  input  logic [SZ_W-1:0]   size_sel,
  input  logic              fe_in,
  input  logic              pe_in,
  input  logic              mode_set,
  input  logic              mode_clr,
  output logic              acc_stb,
  output logic [DATA_W-1:0] acc_data,
  output logic              acc_addr,
  output logic              acc_fe,
  output logic              acc_pe,
  output logic              mode_on
);
  localparam int unsigned MSB = DATA_W - 1;

  logic ftype;

  mpf_mode_reg u_mode (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (mode_set),
    .clr_i  (mode_clr),
    .mode_q (mode_on)
  );

  mpf_frame_decode #(.DATA_W(DATA_W), .SZ_W(SZ_W)) u_dec (
    .raw_i    (chr_data),
    .stop1_i  (stop1_bit),
    .size_i   (size_sel),
    .masked_o (acc_data),
    .ftype_o  (ftype)
  );

  mpf_accept_gate u_gate (
    .clk     (clk),
    .rst_n   (rst_n),
    .done_i  (chr_done),
    .ftype_i (ftype),
    .mode_i  (mode_on),
    .fe_i    (fe_in),
    .pe_i    (pe_in),
    .acc_o   (acc_stb),
    .fe_o    (acc_fe),
    .pe_o    (acc_pe)
  );

  assign acc_addr = ftype;

  assert_wide_type_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_stb && size_sel >= SZ_W'(mpf_pkg::MPF_WIDE_CODE)) |-> (acc_addr == chr_data[MSB]));
  assert_narrow_type_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_stb && size_sel < SZ_W'(mpf_pkg::MPF_WIDE_CODE)) |-> (acc_addr == stop1_bit));
  assert_min_mask_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (size_sel == '0) |-> (acc_data[MSB:mpf_pkg::MPF_MIN_BITS] == '0));
endmodule

// File: tb/mpf_rx_gate_tb.sv
module mpf_rx_gate_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       chr_done = 1'b0;
  logic [8:0] chr_data = '0;
  logic       stop1_bit = 1'b0;
  logic [2:0] size_sel = '0;
  logic       fe_in = 1'b0;
  logic       pe_in = 1'b0;
  logic       mode_set = 1'b0;
  logic       mode_clr = 1'b0;
  logic       acc_stb, acc_addr, acc_fe, acc_pe, mode_on;
  logic [8:0] acc_data;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mpf_rx_gate dut_i (
    .clk(clk), .rst_n(rst_n), .chr_done(chr_done), .chr_data(chr_data),
    .stop1_bit(stop1_bit), .size_sel(size_sel), .fe_in(fe_in), .pe_in(pe_in),
    .mode_set(mode_set), .mode_clr(mode_clr), .acc_stb(acc_stb),
    .acc_data(acc_data), .acc_addr(acc_addr), .acc_fe(acc_fe),
    .acc_pe(acc_pe), .mode_on(mode_on)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Mode write: pulse from a falling edge, visible after the next rising edge.
  task automatic write_mode(input bit set, input bit clr);
    @(negedge clk);
    mode_set = set; mode_clr = clr;
    @(negedge clk);
    mode_set = 0; mode_clr = 0;
    #1;
  endtask

  function automatic int nbits_of(input int sz);
    return (sz >= 4) ? 9 : sz + 5;
  endfunction

  initial begin
    logic [8:0] pats [4];
    pats[0] = 9'h1FF; pats[1] = 9'h0AA; pats[2] = 9'h155; pats[3] = 9'h100;

    repeat (3) @(negedge clk);
    #1;
    chk("R6 reset mode", mode_on, 0);
    chk("R10 idle strobe", acc_stb, 0);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R6 mode after release", mode_on, 0);

    // R6 register behaviour
    write_mode(1, 0); chk("R6 set", mode_on, 1);
    write_mode(0, 0); chk("R6 hold", mode_on, 1);
    write_mode(0, 1); chk("R6 clear", mode_on, 0);
    write_mode(1, 1); chk("R6 set wins", mode_on, 1);
    write_mode(0, 1); chk("R6 clear again", mode_on, 0);

    // Exhaustive sweep over mode, size, stop bit, errors and patterns
    for (int m = 0; m < 2; m++) begin
      write_mode(m == 1, m == 0);
      chk("R6 sweep mode", mode_on, m);
      for (int sz = 0; sz < 8; sz++)
        for (int sb = 0; sb < 2; sb++)
          for (int er = 0; er < 4; er++)
            for (int p = 0; p < 4; p++) begin
              int nb;
              bit ft, pass;
              logic [8:0] msk;
              @(negedge clk);
              chr_data = pats[p]; stop1_bit = sb[0]; size_sel = 3'(sz);
              fe_in = er[0]; pe_in = er[1]; chr_done = 1'b1;
              #1;
              nb   = nbits_of(sz);
              msk  = 9'((1 << nb) - 1);
              ft   = (sz >= 4) ? pats[p][8] : sb[0];
              pass = (m == 0) || ft;
              if (m == 0) chk("R5 open accept", acc_stb, 1);
              else if (ft) chk("R4 address accept", acc_stb, 1);
              else chk("R3 data dropped", acc_stb, 0);
              if (pass) begin
                if (sz >= 4) chk("R1 ninth bit type", acc_addr, ft);
                else chk("R2 stop bit type", acc_addr, ft);
                chk("R8 masked data", acc_data, pats[p] & msk);
              end
              chk("R9 frame error", acc_fe, pass & er[0]);
              chk("R9 parity error", acc_pe, pass & er[1]);
              @(negedge clk);
              chr_done = 1'b0;
              #1;
              chk("R10 no strobe without done", acc_stb, 0);
              chk("R9 errors quiet without accept", {acc_fe, acc_pe}, 0);
            end
    end

    // R7: mode write in the same cycle as a data character (mode currently on)
    @(negedge clk);
    chr_data = 9'h055; size_sel = 3'd7; stop1_bit = 1'b1; fe_in = 1'b1; pe_in = 1'b0;
    chr_done = 1'b1; mode_clr = 1'b1;
    #1;
    chk("R7 old mode still filters", acc_stb, 0);
    chk("R7 dropped keeps fe low", acc_fe, 0);
    @(negedge clk);
    mode_clr = 1'b0;
    #1;
    chk("R7 same data passes next cycle", acc_stb, 1);
    chk("R7 mode now off", mode_on, 0);
    // set in same cycle as data character: accepted with old (off) mode
    @(negedge clk);
    mode_set = 1'b1;
    #1;
    chk("R7 set does not block current", acc_stb, 1);
    @(negedge clk);
    mode_set = 1'b0;
    #1;
    chk("R7 data blocked after set", acc_stb, 0);
    @(negedge clk);
    chr_done = 1'b0;

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule